// File: doc/BRIEF.md
# Reconfigurable Block Transpose-Form FIR Filter

This block is a multi-channel FIR filter that handles L samples per clock. Each accepted block of L signed input samples is turned into an L-row input matrix. The rows are built from the current block and the block accepted before it. M = N/L inner-product units each multiply that matrix by one L-tap slice of the active coefficient set. An adder chain then sums the partial blocks. Registers sit between the stages of that chain, one per stage and not one per tap, so each output block collects the contributions of the last M input blocks.

A constant coefficient bank holds NUM_CH complete filters. A channel select that arrives with each block picks the filter. The result is emitted at full precision, one cycle after the block is accepted, under a simple two-state valid controller. Its state WAIT means no block was accepted on the previous edge and `out_valid` is low. Its state EMIT means a block was accepted and its results are on `out_blk`. Transitions: WAIT→EMIT and EMIT→EMIT when `in_valid` is high at an edge; EMIT→WAIT and WAIT→WAIT when it is low.

Top module: `blkfir_top`

## Requirements
- R1: After reset, `out_valid` is low and all stored history (previous block and chain registers) is zero, so the first outputs equal a convolution with zero samples before the first block.
- R2: A block accepted (`in_valid` high) at a clock edge produces `out_valid` high for exactly the following cycle; `out_valid` is low in any cycle after an edge where `in_valid` was low.
- R3: Input lane l occupies `in_blk[l*16 +: 16]` and output lane l occupies `out_blk[l*38 +: 38]`, lane l being later in time than lane l-1. Output sample n is y(n) = sum over t=0..N-1 of c[t]*x(n-t).
- R4: Samples and coefficients are 16-bit two's complement; each output is a 38-bit signed, unrounded, unwrapped sum (16+16+log2(N) bits).
- R5: Coefficient t (0..N-1) of channel ch is ((t*(2*ch+3) + 5*ch + 1) mod 97) - 48; `in_chan` is a 2-bit channel number for the default NUM_CH = 4.
- R6: The channel select is sampled with each accepted block and applies to every product formed from that block. When the select changes, output sample kL+l equals the sum over m, i of c_ch(k-m)[mL+i]*x((k-m)L+l-i), where ch(j) is the channel sent with block j.
- R7: Cycles with `in_valid` low change no state: `out_blk` holds its value, `in_blk` and `in_chan` are ignored, and later results equal those of the same block stream without the gap.
- R8: The controller holds WAIT after reset and follows the WAIT/EMIT transitions listed above. `out_valid` is high exactly in EMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_blk | input | L*DW (64) | L input samples, lane 0 oldest |
| in_chan | input | CHW (2) | Coefficient set for this block |
| out_valid | output | 1 | `out_blk` holds a fresh block |
| out_blk | output | L*AW (152) | L full-precision output samples |

## Verification
The assertions watch the handshake and the hold behaviour on every cycle. They check that each accepted block yields `out_valid` on the next cycle, that an idle cycle drops it, that an idle cycle freezes the output and the stored history, and that history is clear straight after reset. The numeric results can only be shown by the bench's scenarios. Those scenarios cover an impulse that reads out the taps, random streams on every channel, extreme-amplitude blocks, streams broken by idle gaps carrying junk data, and a select that changes on every block. Each is compared against an arithmetic convolution that follows each block's own channel.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_EMIT = 1'b1
    } blkfir_state_e;

    // Constant coefficient generator for channel ch, tap t.
    function automatic int blkfir_tap(input int ch, input int t);
        int v;
        v = ((t * (2 * ch + 3) + 5 * ch + 1) % 97) - 48;
        return v;
    endfunction

endpackage

// File: rtl/blkfir_coef_rom.sv
module blkfir_coef_rom #(
    parameter int L      = 4,
    parameter int N      = 64,
    parameter int NUM_CH = 4,
    parameter int CW     = 16,
    localparam int M     = N / L,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [CHW-1:0]              chan,
    output logic [M-1:0][L-1:0][CW-1:0] wvec
);

    logic [M-1:0][L-1:0][CW-1:0] bank [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar m = 0; m < M; m++) begin : g_vec
            for (genvar i = 0; i < L; i++) begin : g_tap
                assign bank[ch][m][i] = CW'(blkfir_pkg::blkfir_tap(ch, m * L + i));
            end
        end
    end

    // Whole set available in the same cycle the select is presented.
    always_comb begin
        wvec = bank[chan];
    end

endmodule

// File: rtl/blkfir_reg_unit.sv
module blkfir_reg_unit #(
    parameter int L  = 4,
    parameter int DW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [L-1:0][DW-1:0]         cur,
    output logic [L-1:0][L-1:0][DW-1:0]  rows
);

    logic [L-1:0][DW-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= cur;
        end
    end

    // Row l, column i holds x(kL + l - i); negative offsets reach into prev_q.
    for (genvar l = 0; l < L; l++) begin : g_row
        for (genvar i = 0; i < L; i++) begin : g_col
            if (i <= l) begin : g_cur
                assign rows[l][i] = cur[l - i];
            end else begin : g_prev
                assign rows[l][i] = prev_q[L + l - i];
            end
        end
    end

    assert_hist_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (prev_q == '0));

    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prev_q));

endmodule

// File: rtl/blkfir_ipu.sv
module blkfir_ipu #(
    parameter int L  = 4,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 38
) (
    input  logic [L-1:0][L-1:0][DW-1:0] rows,
    input  logic [L-1:0][CW-1:0]        wv,
    output logic [L-1:0][AW-1:0]        part
);

    // One L-point inner-product cell per matrix row, all sharing wv.
    for (genvar l = 0; l < L; l++) begin : g_cell
        logic signed [AW-1:0] dot;
        always_comb begin
            dot = '0;
            for (int i = 0; i < L; i++) begin
                dot = dot + AW'($signed(rows[l][i]) * $signed(wv[i]));
            end
        end
        assign part[l] = dot;
    end

endmodule

// File: rtl/blkfir_adder_chain.sv
module blkfir_adder_chain #(
    parameter int L  = 4,
    parameter int M  = 16,
    parameter int AW = 38
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [M-1:0][L-1:0][AW-1:0] part,
    output logic [L-1:0][AW-1:0]        y
);

    // dly[m] holds stage m's sum from the previous block; dly[0], dly[M] stay zero.
    logic [L-1:0][AW-1:0] dly [M+1];
    logic [L-1:0][AW-1:0] sum [M];

    always_comb begin
        for (int m = 0; m < M; m++) begin
            for (int l = 0; l < L; l++) begin
                sum[m][l] = part[m][l] + dly[m + 1][l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m <= M; m++) begin
                dly[m] <= '0;
            end
        end else if (en) begin
            for (int m = 1; m < M; m++) begin
                dly[m] <= sum[m];
            end
        end
    end

    assign y = sum[0];

endmodule

// File: rtl/blkfir_top.sv
module blkfir_top #(
    parameter int L      = 4,
    parameter int N      = 64,
    parameter int NUM_CH = 4,
    parameter int DW     = 16,
    parameter int CW     = 16,
    localparam int M     = N / L,
    localparam int AW    = DW + CW + $clog2(N),
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [L*DW-1:0]   in_blk,
    input  logic [CHW-1:0]    in_chan,
    output logic              out_valid,
    output logic [L*AW-1:0]   out_blk
);

    import blkfir_pkg::*;

    logic [L-1:0][DW-1:0]         cur;
    logic [L-1:0][L-1:0][DW-1:0]  rows;
    logic [M-1:0][L-1:0][CW-1:0]  wvec;
    logic [M-1:0][L-1:0][AW-1:0]  part;
    logic [L-1:0][AW-1:0]         y;
    logic [L-1:0][AW-1:0]         out_q;

    blkfir_state_e state_q, state_d;

    assign cur = in_blk;

    blkfir_coef_rom #(.L(L), .N(N), .NUM_CH(NUM_CH), .CW(CW)) u_rom (
        .chan (in_chan),
        .wvec (wvec)
    );

    blkfir_reg_unit #(.L(L), .DW(DW)) u_ru (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cur      (cur),
        .rows     (rows)
    );

    for (genvar m = 0; m < M; m++) begin : g_ipu
        blkfir_ipu #(.L(L), .DW(DW), .CW(CW), .AW(AW)) u_ipu (
            .rows (rows),
            .wv   (wvec[m]),
            .part (part[m])
        );
    end

    blkfir_adder_chain #(.L(L), .M(M), .AW(AW)) u_pau (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .part  (part),
        .y     (y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (in_valid) begin
            out_q <= y;
        end
    end

    assign out_blk = out_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_WAIT: state_d = in_valid ? ST_EMIT : ST_WAIT;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_WAIT: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    assert_emit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_blk));

endmodule

// File: tb/blkfir_top_tb.sv
module blkfir_top_tb;
    localparam int L   = 4;
    localparam int N   = 64;
    localparam int M   = N / L;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int AW  = DW + CW + $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [L*DW-1:0] in_blk;
    logic [1:0]      in_chan;
    logic            out_valid;
    logic [L*AW-1:0] out_blk;

    int checks = 0;
    int errors = 0;
    int nblk   = 0;
    int xs  [0:8191];
    int chs [0:2047];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    blkfir_top #(.L(L), .N(N), .NUM_CH(NCH), .DW(DW), .CW(CW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_blk    (in_blk),
        .in_chan   (in_chan),
        .out_valid (out_valid),
        .out_blk   (out_blk)
    );

    function automatic int ref_tap(input int ch, input int t);
        return ((t * (2 * ch + 3) + 5 * ch + 1) % 97) - 48;
    endfunction

    // Output sample kL+l, each source block weighted by its own channel.
    function automatic longint ref_out(input int k, input int l);
        longint s = 0;
        for (int m = 0; m < M; m++) begin
            int j = k - m;
            if (j >= 0) begin
                for (int i = 0; i < L; i++) begin
                    int idx = j * L + l - i;
                    if (idx >= 0) s += longint'(ref_tap(chs[j], m * L + i)) * longint'(xs[idx]);
                end
            end
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int ch, input int s0, input int s1, input int s2, input int s3,
                        input string req);
        int smp [L];
        smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = 2'(ch);
        for (int l = 0; l < L; l++) begin
            in_blk[l*DW +: DW] = DW'(smp[l]);
            xs[nblk*L + l] = smp[l];
        end
        chs[nblk] = ch;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b1, {req, " R2 R8 valid"}, longint'(out_valid), 1);
        for (int l = 0; l < L; l++) begin
            longint act = longint'($signed(out_blk[l*AW +: AW]));
            longint exp = ref_out(nblk, l);
            chk(act == exp, req, act, exp);
        end
        nblk++;
    endtask

    task automatic rnd_send(input int ch, input string req);
        send(ch, $signed(16'($urandom)), $signed(16'($urandom)),
             $signed(16'($urandom)), $signed(16'($urandom)), req);
    endtask

    task automatic idle();
        logic [L*AW-1:0] snap;
        @(negedge clk);
        in_valid = 1'b0;
        in_blk   = {$urandom, $urandom};
        in_chan  = 2'($urandom);
        snap     = out_blk;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R8 R2 idle valid", longint'(out_valid), 0);
        chk(out_blk == snap, "R7 idle hold", longint'(out_blk[AW-1:0]), longint'(snap[AW-1:0]));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_blk   = '0;
        in_chan  = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(out_blk == '0, "R1 reset data", longint'(out_blk[AW-1:0]), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3: impulse reads the channel-0 taps back in order
        send(0, 1, 0, 0, 0, "R1 R3 impulse");
        for (int b = 0; b < M + 1; b++) send(0, 0, 0, 0, 0, "R3 impulse tail");

        // R5: each channel with random data
        for (int ch = 0; ch < NCH; ch++) begin
            for (int b = 0; b < M + 6; b++) rnd_send(ch, "R5 channel stream");
        end

        // R4: extreme amplitudes
        for (int b = 0; b < M + 2; b++) send(3, -32768, -32768, -32768, -32768, "R4 min");
        for (int b = 0; b < M + 2; b++) send(3, 32767, -32768, 32767, -32768, "R4 alt");
        for (int b = 0; b < M + 2; b++) send(1, 32767, 32767, 32767, 32767, "R4 max");

        // R7: idle gaps with junk on the inputs
        for (int b = 0; b < 60; b++) begin
            rnd_send(2, "R7 gapped stream");
            for (int g = 0; g < int'($urandom % 3); g++) idle();
        end

        // R6: channel changes on every block
        for (int b = 0; b < 80; b++) rnd_send(int'($urandom % NCH), "R6 switching");
        for (int b = 0; b < 20; b++) rnd_send(b % NCH, "R6 rotating");

        idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule